// File: doc/BRIEF.md
# Oscillator Drift Checker and Base Tracker

This block judges the result of a write-clock oscillator measurement taken on one rank of memory devices. For every device on the rank it receives two bytes from the measurement sequencer, joins them into a 16-bit count and either records that count as the device's reference (the base) or compares it with the reference already held for that device and chip select. A count of all ones marks a measurement that overflowed. Such a count is set aside, and the other devices on the rank are still judged.

Each measurement carries a kind: a baseline capture (taken after initialization or a frequency change), a software request, or a periodic check. A baseline capture writes the bases and signals function code 1 on the DFI function output. A check whose absolute difference exceeds the variance limit on any device raises the out-of-variance status. It then rewrites the base only for the devices that drifted and signals function code 2. Each code is held with its valid strobe for a programmable number of cycles. Three sticky status bits report overflow, drift and software-request completion, and a write-one-to-clear input clears them. A read port returns the stored bases of one chip select.

Top module: `osc_drift_tracker`

## Requirements
- R1: Device d's count is {hi byte, lo byte}, taken from `meas_hi[d*8+:8]` (high byte) and `meas_lo[d*8+:8]` (low byte).
- R2: A measurement of kind 2'd2 (baseline) stores each non-overflowed device's count as that device's base for chip select `meas_cs`, readable on `base_rd_val[d*16+:16]` when `base_rd_cs` selects it.
- R3: A count of 16'hFFFF sets `irq_status[0]`, leaves that device's base unchanged and excludes it from the comparison, while the other devices are still compared.
- R4: The difference is the unsigned absolute difference between count and base, computed without wraparound; a device drifts only when it is strictly greater than `var_limit`, so a difference equal to the limit is in range.
- R5: A non-baseline measurement with at least one drifting device sets `irq_status[1]` and replaces the base of the drifting devices only.
- R6: A software measurement (kind 2'd1) with no drifting device sets `irq_status[2]`; a periodic measurement (kind 2'd0 or 2'd3) with no drift sets no status bit and leaves `dfi_func_valid` low.
- R7: From the cycle after the measurement, `dfi_func_valid` is high for `func_len` cycles, with `dfi_func` = 1 after a baseline and 2 after a drift, and `dfi_func` reads 0 whenever `dfi_func_valid` is low; `func_len` = 0 gives no strobe.
- R8: Status bits are sticky until a 1 is written to the same bit of `irq_clr`; a bit that is being set in the same cycle stays set.
- R9: After reset all bases, all status bits and the DFI outputs are zero.
- R10: Every chip select keeps its own set of bases; a measurement on one leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| meas_valid | input | 1 | One-cycle pulse: a measurement is presented |
| meas_kind | input | 2 | 0 periodic, 1 software, 2 baseline, 3 periodic |
| meas_cs | input | CS_W | Chip select measured |
| meas_lo | input | NUM_DEV*8 | Low count byte of each device |
| meas_hi | input | NUM_DEV*8 | High count byte of each device |
| var_limit | input | 16 | Largest difference still in range |
| func_len | input | 4 | Cycles the DFI function valid strobe is held |
| irq_clr | input | 3 | Write-one-to-clear for the status bits |
| base_rd_cs | input | CS_W | Chip select whose bases are read back |
| base_rd_val | output | NUM_DEV*16 | Stored bases of the selected chip select |
| irq_status | output | 3 | Bit 0 overflow, bit 1 out of variance, bit 2 request complete |
| dfi_func | output | 2 | DFI function code, 0 when idle |
| dfi_func_valid | output | 1 | DFI function valid strobe |

## Verification
On every cycle the assertions check that status bits stay set unless cleared, that no status bit rises without a measurement, that a stored base changes only when the table is told to write it, and that the function code is zero while the strobe is low and a legal code while it is high and held steady mid-strobe. Only the bench's scenarios can show the arithmetic: the exact boundary where a difference equals the limit, the wide differences near zero and all ones, the per-device selection of which bases are replaced, the separation between chip selects, and the exact strobe length for a given setting.

// File: rtl/osc_drift_pkg.sv
package osc_drift_pkg;

    localparam int CNT_W     = 16;
    localparam int IRQ_W     = 3;
    localparam int IRQ_OVF   = 0;
    localparam int IRQ_DRIFT = 1;
    localparam int IRQ_DONE  = 2;

    typedef enum logic [1:0] {
        KIND_PERIODIC = 2'd0,
        KIND_SOFTWARE = 2'd1,
        KIND_BASELINE = 2'd2,
        KIND_SPARE    = 2'd3
    } meas_kind_e;

    typedef enum logic [1:0] {
        FN_NONE     = 2'd0,
        FN_BASELINE = 2'd1,
        FN_DRIFT    = 2'd2
    } dfi_code_e;

    typedef struct packed {
        logic             ovf;
        logic             drift;
        logic [CNT_W-1:0] count;
    } dev_result_t;

    localparam logic [CNT_W-1:0] OVF_SENTINEL = '1;

    // Unsigned distance between two counts, one bit wider than a count
    function automatic logic [CNT_W:0] abs_gap(input logic [CNT_W-1:0] a,
                                               input logic [CNT_W-1:0] b);
        logic [CNT_W:0] d;
        d = {1'b0, a} - {1'b0, b};
        return d[CNT_W] ? (~d + 1'b1) : d;
    endfunction

endpackage

// File: rtl/osc_dev_compare.sv
module osc_dev_compare
    import osc_drift_pkg::*;
(
    input  logic [7:0]       lo_byte,
    input  logic [7:0]       hi_byte,
    input  logic [CNT_W-1:0] base,
    input  logic [CNT_W-1:0] limit,
    output dev_result_t      res
);
    logic [CNT_W-1:0] count;
    logic [CNT_W:0]   gap;

    always_comb begin
        count     = {hi_byte, lo_byte};
        gap       = abs_gap(count, base);
        res.count = count;
        res.ovf   = (count == OVF_SENTINEL);
        res.drift = !res.ovf && (gap > {1'b0, limit});
    end
endmodule

// File: rtl/osc_base_table.sv
module osc_base_table
    import osc_drift_pkg::*;
#(
    parameter int NUM_DEV = 2,
    parameter int NUM_CS  = 2,
    parameter int CS_W    = 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [CS_W-1:0]          wr_cs,
    input  logic [NUM_DEV-1:0]       wr_en,
    input  logic [NUM_DEV*CNT_W-1:0] wr_data,
    input  logic [CS_W-1:0]          cmp_cs,
    output logic [NUM_DEV*CNT_W-1:0] cmp_base,
    input  logic [CS_W-1:0]          rd_cs,
    output logic [NUM_DEV*CNT_W-1:0] rd_base
);
    logic [CNT_W-1:0] base_q [NUM_CS][NUM_DEV];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NUM_CS; c++)
                for (int d = 0; d < NUM_DEV; d++)
                    base_q[c][d] <= '0;
        end else begin
            for (int d = 0; d < NUM_DEV; d++)
                if (wr_en[d] && (int'(wr_cs) < NUM_CS))
                    base_q[wr_cs][d] <= wr_data[d*CNT_W +: CNT_W];
        end
    end

    always_comb begin
        cmp_base = '0;
        rd_base  = '0;
        for (int d = 0; d < NUM_DEV; d++) begin
            if (int'(cmp_cs) < NUM_CS)
                cmp_base[d*CNT_W +: CNT_W] = base_q[cmp_cs][d];
            if (int'(rd_cs) < NUM_CS)
                rd_base[d*CNT_W +: CNT_W] = base_q[rd_cs][d];
        end
    end

    // A base entry moves only when its write enable is raised (R5, R3)
    generate
        for (genvar c = 0; c < NUM_CS; c++) begin : g_chk_cs
            for (genvar d = 0; d < NUM_DEV; d++) begin : g_chk_dev
                assert_base_hold_R5: assert property (@(posedge clk) disable iff (rst)
                    !(wr_en[d] && int'(wr_cs) == c) |=> $stable(base_q[c][d]));
            end
        end
    endgenerate
endmodule

// File: rtl/osc_func_strobe.sv
module osc_func_strobe
    import osc_drift_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  dfi_code_e        code_in,
    input  logic [LEN_W-1:0] len,
    output logic [1:0]       func,
    output logic             func_valid
);
    logic [LEN_W-1:0] cnt_q;
    dfi_code_e        code_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            code_q <= FN_NONE;
        end else if (start) begin
            cnt_q  <= len;
            code_q <= code_in;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign func_valid = (cnt_q != '0);
    assign func       = func_valid ? code_q : FN_NONE;

    assert_idle_code_R7: assert property (@(posedge clk) disable iff (rst)
        !func_valid |-> func == 2'd0);
    assert_legal_code_R7: assert property (@(posedge clk) disable iff (rst)
        func_valid |-> (func == 2'd1 || func == 2'd2));
    assert_code_held_R7: assert property (@(posedge clk) disable iff (rst)
        (cnt_q > 1 && !start) |=> (func_valid && $stable(func)));
endmodule

// File: rtl/osc_drift_tracker.sv
module osc_drift_tracker
    import osc_drift_pkg::*;
#(
    parameter int NUM_DEV = 2,
    parameter int NUM_CS  = 2,
    parameter int LEN_W   = 4,
    localparam int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     meas_valid,
    input  logic [1:0]               meas_kind,
    input  logic [CS_W-1:0]          meas_cs,
    input  logic [NUM_DEV*8-1:0]     meas_lo,
    input  logic [NUM_DEV*8-1:0]     meas_hi,
    input  logic [CNT_W-1:0]         var_limit,
    input  logic [LEN_W-1:0]         func_len,
    input  logic [IRQ_W-1:0]         irq_clr,
    input  logic [CS_W-1:0]          base_rd_cs,
    output logic [NUM_DEV*CNT_W-1:0] base_rd_val,
    output logic [IRQ_W-1:0]         irq_status,
    output logic [1:0]               dfi_func,
    output logic                     dfi_func_valid
);
    meas_kind_e               kind;
    logic [NUM_DEV*CNT_W-1:0] cmp_base;
    logic [NUM_DEV*CNT_W-1:0] wr_data;
    dev_result_t              res [NUM_DEV];
    logic [NUM_DEV-1:0]       ovf_v, drift_v, wr_en;
    logic                     is_base, any_ovf, any_drift, strobe_go;
    logic [IRQ_W-1:0]         irq_set, irq_q;
    dfi_code_e                strobe_code;

    assign kind = meas_kind_e'(meas_kind);

    generate
        for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
            osc_dev_compare u_cmp (
                .lo_byte (meas_lo[d*8 +: 8]),
                .hi_byte (meas_hi[d*8 +: 8]),
                .base    (cmp_base[d*CNT_W +: CNT_W]),
                .limit   (var_limit),
                .res     (res[d])
            );
            assign ovf_v[d]   = res[d].ovf;
            assign drift_v[d] = res[d].drift;
            assign wr_data[d*CNT_W +: CNT_W] = res[d].count;
            assign wr_en[d]   = meas_valid && !res[d].ovf && (is_base || res[d].drift);
        end
    endgenerate

    always_comb begin
        is_base   = (kind == KIND_BASELINE);
        any_ovf   = |ovf_v;
        any_drift = |drift_v;
        irq_set            = '0;
        irq_set[IRQ_OVF]   = meas_valid && any_ovf;
        irq_set[IRQ_DRIFT] = meas_valid && !is_base && any_drift;
        irq_set[IRQ_DONE]  = meas_valid && (kind == KIND_SOFTWARE) && !any_drift;
        strobe_go   = meas_valid && (is_base || any_drift);
        strobe_code = is_base ? FN_BASELINE : FN_DRIFT;
    end

    osc_base_table #(
        .NUM_DEV (NUM_DEV),
        .NUM_CS  (NUM_CS),
        .CS_W    (CS_W)
    ) u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_cs    (meas_cs),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .cmp_cs   (meas_cs),
        .cmp_base (cmp_base),
        .rd_cs    (base_rd_cs),
        .rd_base  (base_rd_val)
    );

    osc_func_strobe #(
        .LEN_W (LEN_W)
    ) u_strobe (
        .clk        (clk),
        .rst        (rst),
        .start      (strobe_go),
        .code_in    (strobe_code),
        .len        (func_len),
        .func       (dfi_func),
        .func_valid (dfi_func_valid)
    );

    // Sticky status: a set in the same cycle overrides the clear
    always_ff @(posedge clk) begin
        if (rst) irq_q <= '0;
        else     irq_q <= (irq_q & ~irq_clr) | irq_set;
    end
    assign irq_status = irq_q;

    assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((irq_status & $past(irq_status & ~irq_clr)) == $past(irq_status & ~irq_clr)));
    assert_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        !meas_valid |=> ((irq_status & ~$past(irq_status)) == '0));
    assert_no_strobe_start_R7: assert property (@(posedge clk) disable iff (rst)
        (!meas_valid && !dfi_func_valid) |=> !dfi_func_valid);
endmodule

// File: tb/osc_drift_tracker_test.sv
module osc_drift_tracker_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        meas_valid;
    logic [1:0]  meas_kind;
    logic        meas_cs;
    logic [15:0] meas_lo, meas_hi;
    logic [15:0] var_limit;
    logic [3:0]  func_len;
    logic [2:0]  irq_clr;
    logic        base_rd_cs;
    logic [31:0] base_rd_val;
    logic [2:0]  irq_status;
    logic [1:0]  dfi_func;
    logic        dfi_func_valid;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    osc_drift_tracker uut (
        .clk(clk), .rst(rst), .meas_valid(meas_valid), .meas_kind(meas_kind),
        .meas_cs(meas_cs), .meas_lo(meas_lo), .meas_hi(meas_hi),
        .var_limit(var_limit), .func_len(func_len), .irq_clr(irq_clr),
        .base_rd_cs(base_rd_cs), .base_rd_val(base_rd_val),
        .irq_status(irq_status), .dfi_func(dfi_func), .dfi_func_valid(dfi_func_valid)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Present one measurement; returns on the falling edge after it was taken
    task automatic measure(input logic [1:0] kind, input logic cs,
                           input logic [15:0] c0, input logic [15:0] c1,
                           input logic [2:0] clr);
        @(negedge clk);
        meas_valid = 1'b1;
        meas_kind  = kind;
        meas_cs    = cs;
        meas_lo    = {c1[7:0], c0[7:0]};
        meas_hi    = {c1[15:8], c0[15:8]};
        irq_clr    = clr;
        @(negedge clk);
        meas_valid = 1'b0;
        irq_clr    = 3'b000;
    endtask

    task automatic clear_irq(input logic [2:0] bits);
        @(negedge clk);
        irq_clr = bits;
        @(negedge clk);
        irq_clr = 3'b000;
    endtask

    task automatic check_bases(input string req, input logic cs,
                               input logic [15:0] b0, input logic [15:0] b1);
        base_rd_cs = cs;
        #1;
        check(req, base_rd_val[15:0], b0);
        check(req, base_rd_val[31:16], b1);
    endtask

    // Count strobe cycles from the current falling edge, checking the code
    task automatic check_strobe(input string req, input logic [1:0] code, input int len);
        int cnt = 0;
        while (dfi_func_valid && cnt < 20) begin
            check(req, dfi_func, code);
            cnt++;
            @(negedge clk);
        end
        check(req, cnt, len);
        check(req, dfi_func, 2'd0);
    endtask

    task automatic t_reset;
        check("R9 status", irq_status, 3'b000);
        check("R9 dfi", {dfi_func_valid, dfi_func}, 3'b000);
        check_bases("R9 base cs0", 1'b0, 16'h0, 16'h0);
        check_bases("R9 base cs1", 1'b1, 16'h0, 16'h0);
    endtask

    task automatic t_baseline;
        measure(2'd2, 1'b0, 16'd1000, 16'd2000, 3'b000);
        check("R2 no irq", irq_status, 3'b000);
        check_strobe("R7 baseline strobe", 2'd1, 3);
        check_bases("R2 R1 base stored", 1'b0, 16'd1000, 16'd2000);
    endtask

    task automatic t_in_range;
        measure(2'd0, 1'b0, 16'd1010, 16'd1990, 3'b000);
        check("R6 periodic quiet", irq_status, 3'b000);
        check("R6 no strobe", dfi_func_valid, 1'b0);
        measure(2'd0, 1'b0, 16'd1016, 16'd1984, 3'b000);
        check("R4 equal limit in range", irq_status, 3'b000);
        check("R4 no strobe", dfi_func_valid, 1'b0);
        check_bases("R4 base kept", 1'b0, 16'd1000, 16'd2000);
    endtask

    task automatic t_software;
        measure(2'd1, 1'b0, 16'd1005, 16'd2000, 3'b000);
        check("R6 sw complete", irq_status, 3'b100);
        @(negedge clk);
        check("R8 sticky", irq_status, 3'b100);
        clear_irq(3'b100);
        check("R8 w1c", irq_status, 3'b000);
    endtask

    task automatic t_drift_one;
        measure(2'd0, 1'b0, 16'd1000, 16'd2017, 3'b000);
        check("R5 drift irq", irq_status, 3'b010);
        check_strobe("R7 drift strobe", 2'd2, 3);
        check_bases("R5 only drifted replaced", 1'b0, 16'd1000, 16'd2017);
        clear_irq(3'b010);
    endtask

    task automatic t_overflow;
        measure(2'd0, 1'b0, 16'hFFFF, 16'd2117, 3'b000);
        check("R3 ovf and drift", irq_status, 3'b011);
        check_bases("R3 ovf base kept", 1'b0, 16'd1000, 16'd2117);
        clear_irq(3'b011);
        measure(2'd1, 1'b0, 16'hFFFF, 16'd2117, 3'b000);
        check("R3 ovf excluded sw done", irq_status, 3'b101);
        check("R3 no strobe", dfi_func_valid, 1'b0);
        clear_irq(3'b111);
        check("R8 all cleared", irq_status, 3'b000);
    endtask

    task automatic t_chip_selects;
        measure(2'd2, 1'b1, 16'd5, 16'hFFF0, 3'b000);
        check_bases("R10 cs1 stored", 1'b1, 16'd5, 16'hFFF0);
        check_bases("R10 cs0 untouched", 1'b0, 16'd1000, 16'd2117);
        while (dfi_func_valid) @(negedge clk);
        measure(2'd0, 1'b1, 16'hFFF0, 16'd5, 3'b000);
        check("R4 wide gap drift", irq_status, 3'b010);
        check_bases("R4 wide gap replaced", 1'b1, 16'hFFF0, 16'd5);
        check_bases("R10 cs0 still", 1'b0, 16'd1000, 16'd2117);
        clear_irq(3'b010);
    endtask

    task automatic t_zero_len;
        while (dfi_func_valid) @(negedge clk);
        func_len = 4'd0;
        measure(2'd0, 1'b1, 16'd5, 16'hFFF0, 3'b000);
        check("R7 zero len no strobe", dfi_func_valid, 1'b0);
        @(negedge clk);
        check("R7 zero len still none", {dfi_func_valid, dfi_func}, 3'b000);
        check("R5 drift irq zero len", irq_status, 3'b010);
        func_len = 4'd3;
    endtask

    task automatic t_set_beats_clear;
        measure(2'd0, 1'b1, 16'hFFF0, 16'd5, 3'b010);
        check("R8 set beats clear", irq_status, 3'b010);
        check_strobe("R7 strobe len 3", 2'd2, 3);
    endtask

    initial begin
        rst = 1'b1; meas_valid = 1'b0; meas_kind = 2'd0; meas_cs = 1'b0;
        meas_lo = '0; meas_hi = '0; var_limit = 16'd16; func_len = 4'd3;
        irq_clr = 3'b000; base_rd_cs = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_baseline();
        t_in_range();
        t_software();
        t_drift_one();
        t_overflow();
        t_chip_selects();
        t_zero_len();
        t_set_beats_clear();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule